// File: doc/BRIEF.md
# Handshake Fault-Detecting Transition Monitor

This block is a synchronous on-line tester for one asynchronous pipeline stage. It watches the stage's four handshake wires: input request, output request, input acknowledge and output acknowledge. It brings the wires into the clock domain and keeps the last accepted 4-bit state. Each time the synchronized state moves, the block judges the (previous, next) pair.

Ten specific single-signal moves can only occur when a transistor in one of the stage's C-elements is stuck on. When one of these moves is seen, the block raises a permanent fault flag. It also reports which move was caught first and what kind of premature firing that move represents. A state change that flips more than one wire at once cannot be judged as a single step. Such a change raises a separate permanent protocol-error flag. A synchronous clear input rearms the monitor.

Top module: `hs_fault_monitor`

## Requirements
- R1: After reset, fault and proto_err are 0, entry_idx is 0 and fault_class is 0. The stored previous state is {req_in,req_out,ack_in,ack_out} = 1100.
- R2: Each raw input passes through a two-flop synchronizer. A raw change made just after clock edge k shows on the flags after edge k+3, and not before.
- R3: A single-bit change that is not in the fault list leaves fault at 0. Examples are 1100→1101, 1101→1111, 1111→0111 and 0011→0010.
- R4: The state vector is ordered {req_in,req_out,ack_in,ack_out}. These ten moves set fault and report their number on entry_idx: 0001→0101 (1), 0000→0100 (2), 1110→1010 (3), 1010→1011 (4), 1000→1001 (5), 0111→0110 (6), 0101→0100 (7), 1011→1010 (8), 1001→1000 (9) and 1101→1001 (10).
- R5: fault_class encodes the premature firing: 00 is output request rising (entries 1, 2), 01 is output request falling (entries 3, 10), 10 is output acknowledge rising (entries 4, 5) and 11 is output acknowledge falling (entries 6 to 9).
- R6: Once set, fault stays 1 until clr or reset, whatever the inputs do.
- R7: entry_idx and fault_class hold the first detected entry. Later matches do not change them.
- R8: A change of two or more bits sets proto_err, which is sticky, and does no lookup. fault is not set by that change.
- R9: clr is synchronous. It zeroes fault, proto_err, entry_idx and fault_class. It loads the previous state with the current synchronized value, so clearing never creates a transition of its own.
- R10: When the synchronized state equals the stored previous state, nothing is evaluated and no output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of flags and report |
| req_in | input | 1 | Raw input request wire |
| req_out | input | 1 | Raw output request wire |
| ack_in | input | 1 | Raw input acknowledge wire |
| ack_out | input | 1 | Raw output acknowledge wire |
| fault | output | 1 | Sticky stuck-on fault detected |
| proto_err | output | 1 | Sticky multi-bit change seen |
| entry_idx | output | 4 | Number (1 to 10) of first matched move, 0 if none |
| fault_class | output | 2 | Premature-firing class of first matched move |

## Verification
The assertions assume that the handshake wires hold each value for at least the synchronizer depth plus one cycle. Under this assumption, every accepted state differs from the last one by one step as seen through the synchronizer. They also assume that clr is a plain synchronous level. The stimulus changes inputs only on the falling clock edge. It keeps every state for four cycles before the next move, and it lines up each test by pulsing clr once the start state has settled. A multi-bit jump is driven on purpose only in the proto_err test.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  localparam int SIG_W       = 4;
  localparam int IDX_W       = 4;
  localparam int CLS_W       = 2;
  localparam logic [SIG_W-1:0] IDLE_STATE = 4'b1100;

  typedef enum logic [CLS_W-1:0] {
    CLS_ROUT_RISE = 2'b00,
    CLS_ROUT_FALL = 2'b01,
    CLS_AOUT_RISE = 2'b10,
    CLS_AOUT_FALL = 2'b11
  } fd_class_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
    fd_class_e        cls;
  } fd_match_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int          W        = 4,
  parameter int          STAGES   = 2,
  parameter logic [W-1:0] INIT_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= INIT_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[s] <= INIT_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hs_fd_table.sv
module hs_fd_table
  import hs_mon_pkg::*;
(
  input  logic [SIG_W-1:0] prev_st,
  input  logic [SIG_W-1:0] next_st,
  output fd_match_t        match
);
  function automatic fd_match_t lookup(input logic [2*SIG_W-1:0] pair);
    fd_match_t m;
    m = '{hit: 1'b1, idx: '0, cls: CLS_ROUT_RISE};
    case (pair)
      8'b0001_0101: begin m.idx = 4'd1;  m.cls = CLS_ROUT_RISE; end
      8'b0000_0100: begin m.idx = 4'd2;  m.cls = CLS_ROUT_RISE; end
      8'b1110_1010: begin m.idx = 4'd3;  m.cls = CLS_ROUT_FALL; end
      8'b1010_1011: begin m.idx = 4'd4;  m.cls = CLS_AOUT_RISE; end
      8'b1000_1001: begin m.idx = 4'd5;  m.cls = CLS_AOUT_RISE; end
      8'b0111_0110: begin m.idx = 4'd6;  m.cls = CLS_AOUT_FALL; end
      8'b0101_0100: begin m.idx = 4'd7;  m.cls = CLS_AOUT_FALL; end
      8'b1011_1010: begin m.idx = 4'd8;  m.cls = CLS_AOUT_FALL; end
      8'b1001_1000: begin m.idx = 4'd9;  m.cls = CLS_AOUT_FALL; end
      8'b1101_1001: begin m.idx = 4'd10; m.cls = CLS_ROUT_FALL; end
      default:      m.hit = 1'b0;
    endcase
    return m;
  endfunction

  always_comb begin
    match = lookup({prev_st, next_st});
    // R4: every listed move is a single-signal step
    assert_single_step_R4: assert (!match.hit || $countones(prev_st ^ next_st) == 1);
  end
endmodule

// File: rtl/hs_fault_monitor.sv
module hs_fault_monitor
  import hs_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             req_in,
  input  logic             req_out,
  input  logic             ack_in,
  input  logic             ack_out,
  output logic             fault,
  output logic             proto_err,
  output logic [IDX_W-1:0] entry_idx,
  output logic [CLS_W-1:0] fault_class
);
  logic [SIG_W-1:0] raw_vec, cur_vec, prev_q, delta;
  logic             moved, multi;
  fd_match_t        match;

  assign raw_vec = {req_in, req_out, ack_in, ack_out};

  hs_sync #(.W(SIG_W), .STAGES(SYNC_STAGES), .INIT_VAL(IDLE_STATE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(cur_vec)
  );

  hs_fd_table u_table (.prev_st(prev_q), .next_st(cur_vec), .match(match));

  assign delta = cur_vec ^ prev_q;
  assign moved = |delta;
  assign multi = moved && ((delta & (delta - 4'd1)) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= IDLE_STATE;
      fault       <= 1'b0;
      proto_err   <= 1'b0;
      entry_idx   <= '0;
      fault_class <= '0;
    end else if (clr) begin
      prev_q      <= cur_vec;
      fault       <= 1'b0;
      proto_err   <= 1'b0;
      entry_idx   <= '0;
      fault_class <= '0;
    end else if (moved) begin
      prev_q <= cur_vec;
      if (multi) begin
        proto_err <= 1'b1;
      end else if (match.hit) begin
        fault <= 1'b1;
        if (!fault) begin
          entry_idx   <= match.idx;
          fault_class <= match.cls;
        end
      end
    end
  end

  // R6: fault is permanent until clear
  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> fault);
  // R7: first report is held
  assert_first_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> ($stable(entry_idx) && $stable(fault_class)));
  // R4: index range tracks the flag
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault ? (entry_idx >= 4'd1 && entry_idx <= 4'd10) : (entry_idx == '0));
  // R9: clear empties the flags
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!fault && !proto_err && entry_idx == '0));
  // R8: multi-bit jump raises protocol error
  assert_multi_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $countones(cur_vec ^ prev_q) > 1) |=> proto_err);
  // R10: idle state leaves outputs unchanged
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cur_vec == prev_q) |=> ($stable(fault) && $stable(proto_err)));
endmodule

// File: tb/hs_fault_monitor_tb.sv
module hs_fault_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // fields: start[14:11] end[10:7] fault[6] idx[5:2] class[1:0]
  localparam logic [14:0] VEC [NV] = '{
    {4'b0001, 4'b0101, 1'b1, 4'd1,  2'd0},
    {4'b0000, 4'b0100, 1'b1, 4'd2,  2'd0},
    {4'b1110, 4'b1010, 1'b1, 4'd3,  2'd1},
    {4'b1010, 4'b1011, 1'b1, 4'd4,  2'd2},
    {4'b1000, 4'b1001, 1'b1, 4'd5,  2'd2},
    {4'b0111, 4'b0110, 1'b1, 4'd6,  2'd3},
    {4'b0101, 4'b0100, 1'b1, 4'd7,  2'd3},
    {4'b1011, 4'b1010, 1'b1, 4'd8,  2'd3},
    {4'b1001, 4'b1000, 1'b1, 4'd9,  2'd3},
    {4'b1101, 4'b1001, 1'b1, 4'd10, 2'd1},
    {4'b1100, 4'b1101, 1'b0, 4'd0,  2'd0},
    {4'b1101, 4'b1111, 1'b0, 4'd0,  2'd0},
    {4'b1111, 4'b0111, 1'b0, 4'd0,  2'd0},
    {4'b0011, 4'b0010, 1'b0, 4'd0,  2'd0}
  };

  logic clk = 0, rst_n = 0, clr = 0;
  logic [3:0] drv = 4'b1100;
  logic fault, proto_err;
  logic [3:0] entry_idx;
  logic [1:0] fault_class;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_fault_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .req_in(drv[3]), .req_out(drv[2]), .ack_in(drv[1]), .ack_out(drv[0]),
    .fault(fault), .proto_err(proto_err),
    .entry_idx(entry_idx), .fault_class(fault_class)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle_and_clear(input logic [3:0] st);
    drv = st;
    cyc(4);
    clr = 1;
    cyc(1);
    clr = 0;
  endtask

  initial begin
    @(negedge clk);
    cyc(2);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 fault", fault, 0);
    chk("R1 proto_err", proto_err, 0);
    chk("R1 entry_idx", entry_idx, 0);
    chk("R1 class", fault_class, 0);
    cyc(4);
    // R10 / R1: holding the reset state 1100 changes nothing
    chk("R10 idle fault", fault, 0);
    chk("R10 idle proto", proto_err, 0);

    // vector walk: R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      settle_and_clear(VEC[i][14:11]);
      drv = VEC[i][10:7];
      cyc(4);
      chk(VEC[i][6] ? "R4 fault" : "R3 fault", fault, VEC[i][6]);
      chk("R4 entry_idx", entry_idx, VEC[i][5:2]);
      chk("R5 class", fault_class, VEC[i][1:0]);
      chk("R8 no proto_err", proto_err, 0);
    end

    // R2 latency: drive change after a falling edge
    settle_and_clear(4'b1010);
    drv = 4'b1011;
    cyc(2);
    chk("R2 not yet", fault, 0);
    cyc(1);
    chk("R2 after three edges", fault, 1);
    // R7: second match 1011->1010 (entry 8) must not overwrite
    drv = 4'b1010;
    cyc(4);
    chk("R7 idx held", entry_idx, 4);
    chk("R7 class held", fault_class, 2);
    // R6: legal moves afterwards keep fault
    drv = 4'b1110;
    cyc(4);
    drv = 4'b1111;
    cyc(4);
    chk("R6 sticky", fault, 1);

    // R9: clear in a state, then no fault without a move
    clr = 1;
    cyc(1);
    clr = 0;
    chk("R9 fault cleared", fault, 0);
    chk("R9 idx cleared", entry_idx, 0);
    cyc(4);
    chk("R9 no spurious", fault, 0);
    chk("R9 no spurious proto", proto_err, 0);

    // R8: two-bit jump 1100 -> 0101
    settle_and_clear(4'b1100);
    drv = 4'b0101;
    cyc(4);
    chk("R8 proto_err", proto_err, 1);
    chk("R8 no fault", fault, 0);
    // from 0101, entry 7 (0101->0100) still evaluates; proto_err sticky
    drv = 4'b0100;
    cyc(4);
    chk("R8 proto sticky", proto_err, 1);
    chk("R4 after proto", entry_idx, 7);

    // R1: reset mid-run clears everything
    rst_n = 0;
    cyc(1);
    rst_n = 1;
    chk("R1 reset fault", fault, 0);
    chk("R1 reset proto", proto_err, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule